// File: doc/BRIEF.md
# Power-Management Function Configuration Decoder

This block is the configuration and address-decode core of a PCI power-management function. It holds two relocatable I/O base registers, one for a 128-byte power-management register window and one for a 16-byte SMBus register window. Each window has its own enable bit held in a separate configuration byte. Host configuration software writes these registers through a byte-enabled 32-bit port. The block then compares every host I/O address against both bases, raising a hit output for whichever window is enabled and matches.

The block also produces the system control interrupt (SCI). The SCI is a registered level: for the event sources that can interrupt, the block ORs together each status bit ANDed with its enable bit. The SCI is held low when the function has no interrupt pin assigned. A companion output tells the timer logic when an overflow interrupt should be armed. The register files behind the windows and the timer counter itself live outside this block.

Top module: `pmfunc_cfg_decode`

## Requirements
- R1: After reset, the dwords at config offsets 0x48 and 0x90 read 0x00000001, the dwords at offsets 0x40 and 0xD0 read 0x00000000, and both hit outputs are low.
- R2: A write to the dword at 0x48 merges the enabled byte lanes into the old value, then keeps only bits [15:7] and forces bit 0 to 1. The new value reads back from the next cycle.
- R3: A write to the dword at 0x90 merges the enabled byte lanes into the old value, then keeps only bits [15:4] and forces bit 0 to 1.
- R4: Config byte 0x41 (lane 1 of dword 0x40) stores all 8 bits and reads back in that lane, with zeros in the other lanes. Its bit 7 enables the power-management window.
- R5: Config byte 0xD2 (lane 2 of dword 0xD0) keeps only its low 4 bits, with zeros in the other lanes. Its bit 0 enables the SMBus window.
- R6: `pmHit` is high in the same cycle exactly when the window is enabled and `ioAddr[15:7]` equals base bits [15:7].
- R7: `smbHit` is high in the same cycle exactly when the window is enabled and `ioAddr[15:4]` equals base bits [15:4].
- R8: One cycle after the inputs, `sciOut` equals `intPinPresent` AND the OR of `evtStatus & evtEnable` over bits 0 (timer), 5 (global lock), 8 (power button) and 10 (RTC). All other bits have no effect.
- R9: While `intPinPresent` is low, `sciOut` is low one cycle later, whatever the event bits are.
- R10: One cycle after the inputs, `tmrArm` equals `evtEnable[0]` AND NOT `evtStatus[0]`.
- R11: A cycle with `cfgWrEn` low or all byte enables clear changes no register. A write to any other offset changes no register, and any other offset reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 8 | Configuration byte address (dword selected by bits [7:2]) |
| cfgByteEn | input | 4 | Byte-lane enables for the write |
| cfgWrData | input | 32 | Configuration write data |
| cfgRdData | output | 32 | Configuration read data for the dword at `cfgAddr` (combinational) |
| ioAddr | input | 16 | Host I/O address to decode |
| pmHit | output | 1 | Address falls in the enabled power-management window |
| smbHit | output | 1 | Address falls in the enabled SMBus window |
| evtStatus | input | 16 | ACPI PM1 event status bits |
| evtEnable | input | 16 | ACPI PM1 event enable bits |
| intPinPresent | input | 1 | Interrupt pin is assigned to the function |
| sciOut | output | 1 | Registered SCI level |
| tmrArm | output | 1 | Registered request to arm the timer overflow interrupt |

## Verification
The hardest case to reach from the ports is a hit just at a window edge after a partial-lane write: the base must be moved by a write that updates only some byte lanes, and the address must then sit on the first or last byte of the span, or one byte outside it. The stimulus writes random data with random byte enables to both bases and both enable bytes. It then probes addresses built from the bench's own model of the base, plus or minus the span and an offset near the edge. Random event patterns are also run with bits outside the four interrupting sources set, to show those bits do not disturb the SCI.

// File: rtl/pmcfg_pkg.sv
package pmcfg_pkg;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_PM_CTL,
    RD_PM_BASE,
    RD_SMB_BASE,
    RD_SMB_CTL
  } rdSel_e;

  typedef struct packed {
    logic       wrPmCtl;
    logic       wrPmBase;
    logic       wrSmbBase;
    logic       wrSmbCtl;
    logic [3:0] laneEn;
    rdSel_e     rdSel;
  } cfgStrobe_t;

  // Event bit positions of the interrupting sources
  localparam int EVT_TMR_BIT  = 0;
  localparam int EVT_GBL_BIT  = 5;
  localparam int EVT_PWRB_BIT = 8;
  localparam int EVT_RTC_BIT  = 10;

  function automatic logic [31:0] mergeLanes(input logic [31:0] oldVal,
                                             input logic [31:0] newVal,
                                             input logic [3:0]  lanes);
    logic [31:0] res;
    for (int b = 0; b < 4; b++) begin
      res[8*b +: 8] = lanes[b] ? newVal[8*b +: 8] : oldVal[8*b +: 8];
    end
    return res;
  endfunction

endpackage

// File: rtl/pmcfg_ctrl.sv
module pmcfg_ctrl
  import pmcfg_pkg::*;
#(
  parameter logic [7:0] PM_CTL_OFS   = 8'h41,
  parameter logic [7:0] PM_BASE_OFS  = 8'h48,
  parameter logic [7:0] SMB_BASE_OFS = 8'h90,
  parameter logic [7:0] SMB_CTL_OFS  = 8'hd2
) (
  input  logic       cfgWrEn,
  input  logic [7:0] cfgAddr,
  input  logic [3:0] cfgByteEn,
  output cfgStrobe_t strobe
);

  localparam logic [7:0] DW_MASK = 8'hfc;

  logic selPmCtl, selPmBase, selSmbBase, selSmbCtl;
  logic anyWrite;

  assign selPmCtl   = (cfgAddr & DW_MASK) == (PM_CTL_OFS & DW_MASK);
  assign selPmBase  = (cfgAddr & DW_MASK) == (PM_BASE_OFS & DW_MASK);
  assign selSmbBase = (cfgAddr & DW_MASK) == (SMB_BASE_OFS & DW_MASK);
  assign selSmbCtl  = (cfgAddr & DW_MASK) == (SMB_CTL_OFS & DW_MASK);
  assign anyWrite   = cfgWrEn && (cfgByteEn != 4'b0000);

  always_comb begin
    strobe.laneEn    = cfgByteEn;
    strobe.wrPmCtl   = anyWrite && selPmCtl  && cfgByteEn[PM_CTL_OFS[1:0]];
    strobe.wrSmbCtl  = anyWrite && selSmbCtl && cfgByteEn[SMB_CTL_OFS[1:0]];
    strobe.wrPmBase  = anyWrite && selPmBase;
    strobe.wrSmbBase = anyWrite && selSmbBase;
    if (selPmCtl)        strobe.rdSel = RD_PM_CTL;
    else if (selPmBase)  strobe.rdSel = RD_PM_BASE;
    else if (selSmbBase) strobe.rdSel = RD_SMB_BASE;
    else if (selSmbCtl)  strobe.rdSel = RD_SMB_CTL;
    else                 strobe.rdSel = RD_NONE;
  end

endmodule

// File: rtl/pmcfg_window.sv
module pmcfg_window #(
  parameter int CFG_W     = 32,
  parameter int IO_W      = 16,
  parameter int SPAN_LOG2 = 7
) (
  input  logic [IO_W-1:0]  ioAddr,
  input  logic [CFG_W-1:0] base,
  input  logic             enable,
  output logic             hit
);

  localparam logic [CFG_W-1:0] IO_ONES = {{(CFG_W-IO_W){1'b0}}, {IO_W{1'b1}}};
  localparam logic [CFG_W-1:0] MATCH_MASK = IO_ONES & ~((CFG_W'(1) << SPAN_LOG2) - CFG_W'(1));

  logic [CFG_W-1:0] ioWide;

  assign ioWide = {{(CFG_W-IO_W){1'b0}}, ioAddr};
  assign hit    = enable && (((ioWide ^ base) & MATCH_MASK) == '0);

endmodule

// File: rtl/pmcfg_dp.sv
module pmcfg_dp
  import pmcfg_pkg::*;
#(
  parameter int          CFG_W        = 32,
  parameter int          IO_W         = 16,
  parameter int          EVT_W        = 16,
  parameter int          PM_SPAN_LOG2 = 7,
  parameter int          SMB_SPAN_LOG2 = 4,
  parameter int          SMB_CTL_BITS = 4,
  parameter logic [1:0]  PM_CTL_LANE  = 2'd1,
  parameter logic [1:0]  SMB_CTL_LANE = 2'd2
) (
  input  logic             clk,
  input  logic             rstN,
  input  cfgStrobe_t       strobe,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic [CFG_W-1:0] cfgRdData,
  input  logic [EVT_W-1:0] evtStatus,
  input  logic [EVT_W-1:0] evtEnable,
  input  logic             intPinPresent,
  output logic [CFG_W-1:0] pmBaseQ,
  output logic [CFG_W-1:0] smbBaseQ,
  output logic [7:0]       pmCtlQ,
  output logic [7:0]       smbCtlQ,
  output logic             sciOut,
  output logic             tmrArm
);

  localparam logic [CFG_W-1:0] IO_ONES  = {{(CFG_W-IO_W){1'b0}}, {IO_W{1'b1}}};
  localparam logic [CFG_W-1:0] PM_MASK  = IO_ONES & ~((CFG_W'(1) << PM_SPAN_LOG2) - CFG_W'(1));
  localparam logic [CFG_W-1:0] SMB_MASK = IO_ONES & ~((CFG_W'(1) << SMB_SPAN_LOG2) - CFG_W'(1));
  localparam logic [CFG_W-1:0] BASE_RST = CFG_W'(1);
  localparam logic [7:0]       SMB_CTL_MASK = 8'((1 << SMB_CTL_BITS) - 1);
  localparam logic [EVT_W-1:0] SCI_SRC_MASK =
    (EVT_W'(1) << EVT_TMR_BIT)  | (EVT_W'(1) << EVT_GBL_BIT) |
    (EVT_W'(1) << EVT_PWRB_BIT) | (EVT_W'(1) << EVT_RTC_BIT);

  logic [CFG_W-1:0] pmBaseNext, smbBaseNext;
  logic [7:0]       pmCtlByte, smbCtlByte;
  logic             sciLevel, tmrArmNext;

  assign pmBaseNext  = (mergeLanes(pmBaseQ, cfgWrData, strobe.laneEn) & PM_MASK) | BASE_RST;
  assign smbBaseNext = (mergeLanes(smbBaseQ, cfgWrData, strobe.laneEn) & SMB_MASK) | BASE_RST;
  assign pmCtlByte   = cfgWrData[8*PM_CTL_LANE +: 8];
  assign smbCtlByte  = cfgWrData[8*SMB_CTL_LANE +: 8] & SMB_CTL_MASK;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pmBaseQ  <= BASE_RST;
      smbBaseQ <= BASE_RST;
      pmCtlQ   <= '0;
      smbCtlQ  <= '0;
    end else begin
      if (strobe.wrPmBase)  pmBaseQ  <= pmBaseNext;
      if (strobe.wrSmbBase) smbBaseQ <= smbBaseNext;
      if (strobe.wrPmCtl)   pmCtlQ   <= pmCtlByte;
      if (strobe.wrSmbCtl)  smbCtlQ  <= smbCtlByte;
    end
  end

  always_comb begin
    cfgRdData = '0;
    unique case (strobe.rdSel)
      RD_PM_CTL:   cfgRdData[8*PM_CTL_LANE +: 8]  = pmCtlQ;
      RD_PM_BASE:  cfgRdData = pmBaseQ;
      RD_SMB_BASE: cfgRdData = smbBaseQ;
      RD_SMB_CTL:  cfgRdData[8*SMB_CTL_LANE +: 8] = smbCtlQ;
      default:     cfgRdData = '0;
    endcase
  end

  assign sciLevel   = |(evtStatus & evtEnable & SCI_SRC_MASK);
  assign tmrArmNext = evtEnable[EVT_TMR_BIT] && !evtStatus[EVT_TMR_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sciOut <= 1'b0;
      tmrArm <= 1'b0;
    end else begin
      sciOut <= sciLevel && intPinPresent;
      tmrArm <= tmrArmNext;
    end
  end

endmodule

// File: rtl/pmfunc_cfg_decode.sv
module pmfunc_cfg_decode
  import pmcfg_pkg::*;
#(
  parameter int         CFG_W         = 32,
  parameter int         IO_W          = 16,
  parameter int         EVT_W         = 16,
  parameter int         PM_SPAN_LOG2  = 7,
  parameter int         SMB_SPAN_LOG2 = 4,
  parameter int         SMB_CTL_BITS  = 4,
  parameter int         PM_EN_BIT     = 7,
  parameter int         SMB_EN_BIT    = 0,
  parameter logic [7:0] PM_CTL_OFS    = 8'h41,
  parameter logic [7:0] PM_BASE_OFS   = 8'h48,
  parameter logic [7:0] SMB_BASE_OFS  = 8'h90,
  parameter logic [7:0] SMB_CTL_OFS   = 8'hd2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [7:0]       cfgAddr,
  input  logic [3:0]       cfgByteEn,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic [CFG_W-1:0] cfgRdData,
  input  logic [IO_W-1:0]  ioAddr,
  output logic             pmHit,
  output logic             smbHit,
  input  logic [EVT_W-1:0] evtStatus,
  input  logic [EVT_W-1:0] evtEnable,
  input  logic             intPinPresent,
  output logic             sciOut,
  output logic             tmrArm
);

  cfgStrobe_t       strobe;
  logic [CFG_W-1:0] pmBaseQ, smbBaseQ;
  logic [7:0]       pmCtlQ, smbCtlQ;

  pmcfg_ctrl #(
    .PM_CTL_OFS(PM_CTL_OFS), .PM_BASE_OFS(PM_BASE_OFS),
    .SMB_BASE_OFS(SMB_BASE_OFS), .SMB_CTL_OFS(SMB_CTL_OFS)
  ) u_ctrl (
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgByteEn(cfgByteEn), .strobe(strobe)
  );

  pmcfg_dp #(
    .CFG_W(CFG_W), .IO_W(IO_W), .EVT_W(EVT_W),
    .PM_SPAN_LOG2(PM_SPAN_LOG2), .SMB_SPAN_LOG2(SMB_SPAN_LOG2),
    .SMB_CTL_BITS(SMB_CTL_BITS),
    .PM_CTL_LANE(PM_CTL_OFS[1:0]), .SMB_CTL_LANE(SMB_CTL_OFS[1:0])
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .evtStatus(evtStatus), .evtEnable(evtEnable),
    .intPinPresent(intPinPresent), .pmBaseQ(pmBaseQ), .smbBaseQ(smbBaseQ),
    .pmCtlQ(pmCtlQ), .smbCtlQ(smbCtlQ), .sciOut(sciOut), .tmrArm(tmrArm)
  );

  pmcfg_window #(.CFG_W(CFG_W), .IO_W(IO_W), .SPAN_LOG2(PM_SPAN_LOG2)) u_pmWin (
    .ioAddr(ioAddr), .base(pmBaseQ), .enable(pmCtlQ[PM_EN_BIT]), .hit(pmHit)
  );

  pmcfg_window #(.CFG_W(CFG_W), .IO_W(IO_W), .SPAN_LOG2(SMB_SPAN_LOG2)) u_smbWin (
    .ioAddr(ioAddr), .base(smbBaseQ), .enable(smbCtlQ[SMB_EN_BIT]), .hit(smbHit)
  );

endmodule

// File: rtl/pmcfg_checker.sv
module pmcfg_checker #(
  parameter int CFG_W = 32,
  parameter int EVT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWrEn,
  input logic [CFG_W-1:0] pmBaseQ,
  input logic [CFG_W-1:0] smbBaseQ,
  input logic [7:0]       pmCtlQ,
  input logic [7:0]       smbCtlQ,
  input logic             pmHit,
  input logic             smbHit,
  input logic [EVT_W-1:0] evtStatus,
  input logic             intPinPresent,
  input logic             sciOut,
  input logic             tmrArm
);

  // R2
  pm_base_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    pmBaseQ[0] && ((pmBaseQ & ~CFG_W'(32'h0000ff81)) == '0));

  // R3
  smb_base_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    smbBaseQ[0] && ((smbBaseQ & ~CFG_W'(32'h0000fff1)) == '0));

  // R6
  pm_hit_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    pmHit |-> pmCtlQ[7]);

  // R7
  smb_hit_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    smbHit |-> smbCtlQ[0]);

  // R5
  smb_ctl_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    smbCtlQ[7:4] == 4'h0);

  // R9
  sci_no_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    !intPinPresent |=> !sciOut);

  // R10
  tmr_status_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtStatus[0] |=> !tmrArm);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrEn |=> $stable(pmBaseQ) && $stable(smbBaseQ) && $stable(pmCtlQ) && $stable(smbCtlQ));

endmodule

bind pmfunc_cfg_decode pmcfg_checker #(.CFG_W(CFG_W), .EVT_W(EVT_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .pmBaseQ(pmBaseQ), .smbBaseQ(smbBaseQ),
  .pmCtlQ(pmCtlQ), .smbCtlQ(smbCtlQ), .pmHit(pmHit), .smbHit(smbHit),
  .evtStatus(evtStatus), .intPinPresent(intPinPresent), .sciOut(sciOut), .tmrArm(tmrArm)
);

// File: tb/test_pmfunc_cfg_decode.sv
`timescale 1ns/1ps
module test_pmfunc_cfg_decode;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWrEn;
  logic [7:0]  cfgAddr;
  logic [3:0]  cfgByteEn;
  logic [31:0] cfgWrData;
  logic [31:0] cfgRdData;
  logic [15:0] ioAddr;
  logic        pmHit, smbHit;
  logic [15:0] evtStatus, evtEnable;
  logic        intPinPresent;
  logic        sciOut, tmrArm;

  int testCount = 0;
  int failCount = 0;
  int cycles = 0;
  bit finished = 1'b0;

  logic [31:0] mPmBase, mSmbBase;
  logic [7:0]  mPmCtl, mSmbCtl;

  always #5 clk = ~clk;

  pmfunc_cfg_decode i_pmfunc_cfg_decode (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .ioAddr(ioAddr), .pmHit(pmHit), .smbHit(smbHit), .evtStatus(evtStatus),
    .evtEnable(evtEnable), .intPinPresent(intPinPresent), .sciOut(sciOut), .tmrArm(tmrArm)
  );

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = be[b] ? n[8*b +: 8] : o[8*b +: 8];
    return r;
  endfunction

  function automatic logic [31:0] expRead(input logic [7:0] a);
    case (a & 8'hfc)
      8'h40:   return {16'h0, mPmCtl, 8'h0};
      8'h48:   return mPmBase;
      8'h90:   return mSmbBase;
      8'hd0:   return {8'h0, mSmbCtl, 16'h0};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic expPmHit(input logic [15:0] a);
    return mPmCtl[7] && (a[15:7] == mPmBase[15:7]);
  endfunction

  function automatic logic expSmbHit(input logic [15:0] a);
    return mSmbCtl[0] && (a[15:4] == mSmbBase[15:4]);
  endfunction

  function automatic logic expSci(input logic [15:0] s, input logic [15:0] e, input logic p);
    return p && (|(s & e & 16'h0521));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic modelWrite(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    if (be != 4'b0) begin
      case (a & 8'hfc)
        8'h40: if (be[1]) mPmCtl = d[15:8];
        8'h48: mPmBase = (merge(mPmBase, d, be) & 32'h0000ff80) | 32'h1;
        8'h90: mSmbBase = (merge(mSmbBase, d, be) & 32'h0000fff0) | 32'h1;
        8'hd0: if (be[2]) mSmbCtl = {4'h0, d[19:16]};
        default: ;
      endcase
    end
  endtask

  task automatic cfgWrite(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgByteEn = be; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    modelWrite(a, be, d);
  endtask

  task automatic checkRead(input string req, input logic [7:0] a);
    cfgAddr = a;
    #1;
    chk(req, cfgRdData, expRead(a));
  endtask

  task automatic checkAllRegs(input string req);
    checkRead(req, 8'h41);
    checkRead(req, 8'h48);
    checkRead(req, 8'h90);
    checkRead(req, 8'hd2);
  endtask

  task automatic checkHits(input logic [15:0] a);
    ioAddr = a;
    #1;
    chk("R6 pmHit", {31'h0, pmHit}, {31'h0, expPmHit(a)});
    chk("R7 smbHit", {31'h0, smbHit}, {31'h0, expSmbHit(a)});
  endtask

  task automatic checkEvents(input logic [15:0] s, input logic [15:0] e, input logic p,
                             input string req);
    @(negedge clk);
    evtStatus = s; evtEnable = e; intPinPresent = p;
    @(negedge clk);
    chk(req, {31'h0, sciOut}, {31'h0, expSci(s, e, p)});
    chk("R10 tmrArm", {31'h0, tmrArm}, {31'h0, e[0] && !s[0]});
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !finished) begin
        finished = 1'b1;
        failCount++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("[TB] %0d tests run, %0d failed", testCount, failCount);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    rstN = 1'b0; cfgWrEn = 1'b0; cfgAddr = 8'h0; cfgByteEn = 4'h0; cfgWrData = '0;
    ioAddr = 16'h0; evtStatus = '0; evtEnable = '0; intPinPresent = 1'b0;
    mPmBase = 32'h1; mSmbBase = 32'h1; mPmCtl = 8'h0; mSmbCtl = 8'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    checkAllRegs("R1 reset readback");
    checkHits(16'h0000);
    checkHits(16'h0001);

    // R2 full write to pm base, then enable
    cfgWrite(8'h48, 4'hf, 32'hdeadbeef);
    checkRead("R2 pm base mask", 8'h48);
    cfgWrite(8'h40, 4'h2, 32'h00008000);
    checkRead("R4 pm ctl", 8'h40);
    checkHits({mPmBase[15:7], 7'h00});
    checkHits({mPmBase[15:7], 7'h7f});
    checkHits({mPmBase[15:7], 7'h00} + 16'h80);
    checkHits({mPmBase[15:7], 7'h00} - 16'h1);

    // R3 partial write to smb base, R5 control masking
    cfgWrite(8'h90, 4'h2, 32'hffffabff);
    checkRead("R3 smb base partial", 8'h90);
    cfgWrite(8'hd0, 4'h4, 32'h00ff0000);
    checkRead("R5 smb ctl low nibble", 8'hd0);
    checkHits({mSmbBase[15:4], 4'h0});
    checkHits({mSmbBase[15:4], 4'hf});
    checkHits({mSmbBase[15:4], 4'h0} + 16'h10);

    // R11 no-effect writes
    cfgWrite(8'h48, 4'h0, 32'hffffffff);
    cfgWrite(8'h44, 4'hf, 32'h12345678);
    cfgWrite(8'h40, 4'hd, 32'hffff00ff);
    @(negedge clk);
    cfgWrEn = 1'b0; cfgAddr = 8'h90; cfgByteEn = 4'hf; cfgWrData = 32'h0;
    @(negedge clk);
    checkAllRegs("R11 ignored writes");
    checkRead("R11 other offset reads zero", 8'h44);

    // R4/R5 disable windows then probe
    cfgWrite(8'h40, 4'h2, 32'h00007f00);
    checkHits({mPmBase[15:7], 7'h10});
    cfgWrite(8'hd0, 4'h4, 32'h000e0000);
    checkHits({mSmbBase[15:4], 4'h3});

    // R8/R9/R10 directed
    checkEvents(16'h0001, 16'h0001, 1'b1, "R8 timer src");
    checkEvents(16'h0020, 16'h0020, 1'b1, "R8 global lock src");
    checkEvents(16'h0100, 16'h0100, 1'b1, "R8 power button src");
    checkEvents(16'h0400, 16'h0400, 1'b1, "R8 rtc src");
    checkEvents(16'hfade, 16'hfade & 16'hfade & ~16'h0521, 1'b1, "R8 non-source bits");
    checkEvents(16'hffff, 16'hffff, 1'b0, "R9 no pin");
    checkEvents(16'h0000, 16'h0001, 1'b0, "R10 arm");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0]  a;
      logic [31:0] d;
      logic [3:0]  be;
      logic [15:0] io;
      case ($urandom_range(0, 4))
        0: a = 8'h40 | 8'($urandom_range(0, 3));
        1: a = 8'h48;
        2: a = 8'h90;
        3: a = 8'hd0 | 8'($urandom_range(0, 3));
        default: a = 8'($urandom);
      endcase
      d  = $urandom;
      be = 4'($urandom);
      cfgWrite(a, be, d);
      checkRead("R2 R3 R4 R5 R11 random readback", a);
      io = 16'($urandom);
      case ($urandom_range(0, 3))
        0: io = {mPmBase[15:7], io[6:0]};
        1: io = {mSmbBase[15:4], io[3:0]};
        2: io = {mPmBase[15:7], 7'h0} + (io[0] ? 16'h80 : 16'hffff);
        default: ;
      endcase
      checkHits(io);
      if (i % 4 == 0) begin
        logic [15:0] s, e;
        s = 16'($urandom);
        e = 16'($urandom);
        checkEvents(s, e, 1'($urandom), "R8 R9 random events");
      end
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule